// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block sits downstream of a PWM time base. Each cycle it receives the live counter value, the counting direction and the zero and period strobes. It holds a bank of compare values and raises a registered event strobe whenever the count equals one of them. From these events it drives two PWM levels, A and B. Each output has its own action table, and that table picks one of four effects for each event: set the output, clear it, invert it, or leave it alone.

Each compare value is stored twice. Software writes go to a shadow copy, and the comparator reads an active copy. A per-compare load mode decides when the shadow is copied into the active copy: on a zero strobe, on a period strobe, on either strobe, or immediately at the write. This keeps a new duty cycle from reaching the comparator part-way through a PWM period.

Top module: `pwm_cmp_aq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pwm_a`, `pwm_b` and every `cmp_evt` bit are 0, and every active compare value is 0.
- R2: `cmp_evt[i]` is 1 in the cycle after a cycle in which `cnt` equals active compare value i, and 0 otherwise. Index 0 is compare A, 1 is B, 2 is C and 3 is D.
- R3: When the load mode of compare i is 2'b11 (immediate), a write to compare i changes its active value at the next clock edge.
- R4: Load modes 2'b00, 2'b01 and 2'b10 copy the shadow into the active value only at an edge where, respectively, `evt_zero` is high, `evt_prd` is high, or either one is high. At all other times a write changes only the shadow. If a write and a load happen at the same edge, the written value is the one loaded. Compare i uses the mode in `reload_mode[2i+1:2i]`.
- R5: Action codes are 2'b00 hold, 2'b01 drive low, 2'b10 drive high and 2'b11 invert. The output takes its new level one clock after the cycle in which the event occurred.
- R6: A zero strobe applies the action in bits [1:0] of the output's action configuration.
- R7: A period strobe applies the action in bits [3:2].
- R8: A compare A match applies bits [5:4] when `cnt_up` is 1 and bits [7:6] when `cnt_up` is 0.
- R9: A compare B match applies bits [9:8] when `cnt_up` is 1 and bits [11:10] when `cnt_up` is 0.
- R10: When several events fall on the same cycle, only the highest-priority event whose action is not hold takes effect. The order, highest first, is zero, period, compare A, compare B.
- R11: Output A uses `act_cfg_a` and output B uses `act_cfg_b`. A setting in one table never affects the other output.
- R12: Matches on compares C and D raise their event strobes but never change either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 16 | Time-base counter value |
| cnt_up | input | 1 | 1 while the counter is counting up |
| evt_zero | input | 1 | Counter-at-zero strobe |
| evt_prd | input | 1 | Counter-at-period strobe |
| cmp_wr_en | input | 1 | Compare write strobe |
| cmp_wr_sel | input | 2 | Index of the compare being written |
| cmp_wr_data | input | 16 | Compare write value |
| reload_mode | input | 8 | Load mode, two bits per compare |
| act_cfg_a | input | 12 | Action table for output A |
| act_cfg_b | input | 12 | Action table for output B |
| pwm_a | output | 1 | PWM level A |
| pwm_b | output | 1 | PWM level B |
| cmp_evt | output | 4 | Registered compare-match strobes |

## Verification
The bench sets compare A to zero so that the zero event and the compare A match land on the same cycle. It also puts the period event on top of a compare A match. A design with the priority order wrong would clear the output where it should set it. The bench writes each shadowed compare and then sends it the strobes that must not load it before the one that must. A design that loaded on the wrong strobe would produce a match one ramp too early or too late. The up/down ramp visits each compare value while counting up and again while counting down, and C and D sit on the ramp as well. A design that ignored the direction, or that let C and D drive an output, would produce the wrong duty cycle.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  // Output action codes
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // Shadow-to-active load modes
  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PRD    = 2'b01,
    LD_EITHER = 2'b10,
    LD_NOW    = 2'b11
  } ld_e;

  localparam int ACT_FIELD_W = 2;
  localparam int ACT_FIELDS  = 6;
  localparam int ACT_CFG_W   = ACT_FIELD_W * ACT_FIELDS;

endpackage

// File: rtl/pwm_cmp_slot.sv
module pwm_cmp_slot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic [1:0]       ld_mode,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] act_val,
  output logic             hit_q
);
  import pwm_aq_pkg::*;

  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] active_q, active_d;
  logic             active_en;
  logic             load_evt;
  logic             hit_d;

  always_comb begin
    shadow_d = wr_en ? wr_data : shadow_q;
    case (ld_mode)
      LD_ZERO:   load_evt = evt_zero;
      LD_PRD:    load_evt = evt_prd;
      LD_EITHER: load_evt = evt_zero | evt_prd;
      default:   load_evt = 1'b0;
    endcase
    if (ld_mode == LD_NOW) begin
      active_en = wr_en;
      active_d  = wr_data;
    end else begin
      active_en = load_evt;
      active_d  = shadow_d;
    end
    hit_d = (cnt == active_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      hit_q    <= 1'b0;
    end else begin
      if (wr_en)     shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
      hit_q <= hit_d;
    end
  end

  assign act_val = active_q;

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan #(
  parameter int CFG_W = pwm_aq_pkg::ACT_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic             cnt_up,
  output logic             pwm_q
);
  import pwm_aq_pkg::*;

  logic [1:0] code_z, code_p, code_ca, code_cb, sel;
  logic       pwm_d, pwm_en;

  always_comb begin
    code_z  = evt_zero ? cfg[1:0] : ACT_HOLD;
    code_p  = evt_prd  ? cfg[3:2] : ACT_HOLD;
    code_ca = hit_a ? (cnt_up ? cfg[5:4] : cfg[7:6])   : ACT_HOLD;
    code_cb = hit_b ? (cnt_up ? cfg[9:8] : cfg[11:10]) : ACT_HOLD;

    // fixed priority: zero, period, compare A, compare B
    if (code_z != ACT_HOLD)       sel = code_z;
    else if (code_p != ACT_HOLD)  sel = code_p;
    else if (code_ca != ACT_HOLD) sel = code_ca;
    else                          sel = code_cb;

    case (sel)
      ACT_CLR: pwm_d = 1'b0;
      ACT_SET: pwm_d = 1'b1;
      ACT_TGL: pwm_d = ~pwm_q;
      default: pwm_d = pwm_q;
    endcase
    pwm_en = (sel != ACT_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwm_q <= 1'b0;
    else if (pwm_en) pwm_q <= pwm_d;
  end

endmodule

// File: rtl/pwm_cmp_aq.sv
module pwm_cmp_aq #(
  parameter  int CNT_W   = 16,
  parameter  int NUM_CMP = 4,
  localparam int SEL_W   = $clog2(NUM_CMP),
  localparam int CFG_W   = pwm_aq_pkg::ACT_CFG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt,
  input  logic                 cnt_up,
  input  logic                 evt_zero,
  input  logic                 evt_prd,
  input  logic                 cmp_wr_en,
  input  logic [SEL_W-1:0]     cmp_wr_sel,
  input  logic [CNT_W-1:0]     cmp_wr_data,
  input  logic [2*NUM_CMP-1:0] reload_mode,
  input  logic [CFG_W-1:0]     act_cfg_a,
  input  logic [CFG_W-1:0]     act_cfg_b,
  output logic                 pwm_a,
  output logic                 pwm_b,
  output logic [NUM_CMP-1:0]   cmp_evt
);

  localparam int NUM_OUT = 2;

  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_act;
  logic [NUM_CMP-1:0]            hit_q;
  logic [NUM_OUT-1:0][CFG_W-1:0] cfg_v;
  logic [NUM_OUT-1:0]            pwm_v;

  assign cfg_v = {act_cfg_b, act_cfg_a};

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
    pwm_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .evt_zero (evt_zero),
      .evt_prd  (evt_prd),
      .ld_mode  (reload_mode[2*i +: 2]),
      .wr_en    (cmp_wr_en && (cmp_wr_sel == SEL_W'(i))),
      .wr_data  (cmp_wr_data),
      .act_val  (cmp_act[i]),
      .hit_q    (hit_q[i])
    );
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chan
    pwm_aq_chan #(.CFG_W(CFG_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_v[k]),
      .evt_zero (evt_zero),
      .evt_prd  (evt_prd),
      .hit_a    (cnt == cmp_act[0]),
      .hit_b    (cnt == cmp_act[1]),
      .cnt_up   (cnt_up),
      .pwm_q    (pwm_v[k])
    );
  end

  assign pwm_a   = pwm_v[0];
  assign pwm_b   = pwm_v[1];
  assign cmp_evt = hit_q;

endmodule

// File: rtl/pwm_cmp_aq_chk.sv
module pwm_cmp_aq_chk #(
  parameter  int CNT_W   = 16,
  parameter  int NUM_CMP = 4,
  localparam int SEL_W   = $clog2(NUM_CMP),
  localparam int CFG_W   = pwm_aq_pkg::ACT_CFG_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CNT_W-1:0]              cnt,
  input logic                          evt_zero,
  input logic                          evt_prd,
  input logic                          cmp_wr_en,
  input logic [SEL_W-1:0]              cmp_wr_sel,
  input logic [CNT_W-1:0]              cmp_wr_data,
  input logic [2*NUM_CMP-1:0]          reload_mode,
  input logic [CFG_W-1:0]              act_cfg_a,
  input logic [CFG_W-1:0]              act_cfg_b,
  input logic                          pwm_a,
  input logic                          pwm_b,
  input logic [NUM_CMP-1:0]            cmp_evt,
  input logic [NUM_CMP-1:0][CNT_W-1:0] cmp_act
);

  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_m
    AST_EVT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> (cmp_evt[i] == ($past(cnt) == $past(cmp_act[i])))); // R2
  end

  AST_IMMED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(cmp_wr_en) && ($past(reload_mode[2*cmp_wr_sel +: 2]) == 2'b11)
    |-> cmp_act[$past(cmp_wr_sel)] == $past(cmp_wr_data)); // R3

  AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$past(evt_zero) && !$past(evt_prd) && !$past(cmp_wr_en)
    |-> cmp_act == $past(cmp_act)); // R4

  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$past(evt_zero) && !$past(evt_prd) && !cmp_evt[0] && !cmp_evt[1]
    |-> pwm_a == $past(pwm_a)); // R5

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$past(evt_zero) && !$past(evt_prd) && !cmp_evt[0] && !cmp_evt[1]
    |-> pwm_b == $past(pwm_b)); // R12

  AST_A_ZERO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(evt_zero) && ($past(act_cfg_a[1:0]) == 2'b10) |-> pwm_a); // R6

  AST_B_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(evt_zero) && ($past(act_cfg_b[1:0]) == 2'b01) |-> !pwm_b); // R6

endmodule

bind pwm_cmp_aq pwm_cmp_aq_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt         (cnt),
  .evt_zero    (evt_zero),
  .evt_prd     (evt_prd),
  .cmp_wr_en   (cmp_wr_en),
  .cmp_wr_sel  (cmp_wr_sel),
  .cmp_wr_data (cmp_wr_data),
  .reload_mode (reload_mode),
  .act_cfg_a   (act_cfg_a),
  .act_cfg_b   (act_cfg_b),
  .pwm_a       (pwm_a),
  .pwm_b       (pwm_b),
  .cmp_evt     (cmp_evt),
  .cmp_act     (cmp_act)
);

// File: tb/pwm_cmp_aq_test.sv
module pwm_cmp_aq_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] cnt;
  logic        cnt_up, evt_zero, evt_prd;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [7:0]  reload_mode;
  logic [11:0] cfg_a, cfg_b;
  logic        pwm_a, pwm_b;
  logic [3:0]  cmp_evt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic       a;
    logic       b;
    logic [3:0] e;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // bench model state
  logic [15:0] m_sh  [4];
  logic [15:0] m_act [4];
  logic        m_a, m_b;

  pwm_cmp_aq uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up),
    .evt_zero(evt_zero), .evt_prd(evt_prd),
    .cmp_wr_en(wr_en), .cmp_wr_sel(wr_sel), .cmp_wr_data(wr_data),
    .reload_mode(reload_mode), .act_cfg_a(cfg_a), .act_cfg_b(cfg_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .cmp_evt(cmp_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic resolve(input logic [11:0] c, input logic cur,
                                   input logic z, input logic p,
                                   input logic ma, input logic mb, input logic up);
    logic [1:0] code;
    code = 2'b00;
    if (mb) code = up ? c[9:8] : c[11:10];
    if (ma && ((up ? c[5:4] : c[7:6]) != 2'b00)) code = up ? c[5:4] : c[7:6];
    if (p && c[3:2] != 2'b00) code = c[3:2];
    if (z && c[1:0] != 2'b00) code = c[1:0];
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  // driver: apply one cycle of stimulus, push the expected result
  task automatic step(input logic [15:0] c, input logic up, input logic z,
                      input logic p, input string tag);
    exp_t       x;
    logic [3:0] mt;
    logic [15:0] nsh;
    logic        ld;
    cnt = c; cnt_up = up; evt_zero = z; evt_prd = p;
    for (int i = 0; i < 4; i++) mt[i] = (c == m_act[i]);
    x.a = resolve(cfg_a, m_a, z, p, mt[0], mt[1], up);
    x.b = resolve(cfg_b, m_b, z, p, mt[0], mt[1], up);
    x.e = mt;
    x.tag = tag;
    for (int i = 0; i < 4; i++) begin
      nsh = (wr_en && wr_sel == 2'(i)) ? wr_data : m_sh[i];
      case (reload_mode[2*i +: 2])
        2'b00:   ld = z;
        2'b01:   ld = p;
        2'b10:   ld = z | p;
        default: ld = 1'b0;
      endcase
      if (reload_mode[2*i +: 2] == 2'b11) begin
        if (wr_en && wr_sel == 2'(i)) m_act[i] = wr_data;
      end else if (ld) m_act[i] = nsh;
      m_sh[i] = nsh;
    end
    m_a = x.a; m_b = x.b;
    sb.push_back(x);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write(input logic [1:0] s, input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step(16'd1000, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic ramp(input logic [15:0] prd, input string tag);
    for (int v = 0; v <= int'(prd); v++)
      step(16'(v), 1'b1, v == 0, v == int'(prd), tag);
    for (int v = int'(prd) - 1; v > 0; v--)
      step(16'(v), 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare design results with the scoreboard
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        x = sb.pop_front();
        total++;
        if (pwm_a !== x.a || pwm_b !== x.b || cmp_evt !== x.e) begin
          bad++;
          $display("FAIL %s: a=%b b=%b evt=%b expected a=%b b=%b evt=%b",
                   x.tag, pwm_a, pwm_b, cmp_evt, x.a, x.b, x.e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt = '0; cnt_up = 1'b1; evt_zero = 1'b0; evt_prd = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    reload_mode = 8'hFF; cfg_a = 12'h092; cfg_b = 12'h60D;
    for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    m_a = 1'b0; m_b = 1'b0;
    cnt = 16'd1000;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    total++;
    if (pwm_a !== 1'b0 || pwm_b !== 1'b0 || cmp_evt !== 4'h0) begin
      bad++;
      $display("FAIL R1 reset: a=%b b=%b evt=%b expected a=0 b=0 evt=0000",
               pwm_a, pwm_b, cmp_evt);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(16'd1000, 1'b1, 1'b0, 1'b0, "R1 idle after reset");
    step(16'd0, 1'b1, 1'b0, 1'b0, "R1 R2 active values reset to zero");

    // immediate loads (R3)
    write(2'd0, 16'd10, "R3 immediate write A");
    write(2'd1, 16'd20, "R3 immediate write B");
    write(2'd2, 16'd30, "R3 immediate write C");
    write(2'd3, 16'd40, "R3 immediate write D");
    step(16'd10, 1'b1, 1'b0, 1'b0, "R3 R8 A active after write");

    // up/down ramps: A cfg zero=set, A-up=clear, A-down=set
    // B cfg zero=clear, prd=toggle, B-up=set, B-down=clear
    ramp(16'd50, "R2 R6 R7 R8 R9 R11 R12 ramp");
    ramp(16'd50, "R2 R6 R7 R8 R9 R11 R12 ramp2");

    // R5 encoding: toggle and hold on zero
    cfg_a = 12'h003; cfg_b = 12'h000;
    for (int n = 0; n < 3; n++) step(16'd1000, 1'b1, 1'b1, 1'b0, "R5 toggle on zero");
    cfg_a = 12'h000;
    step(16'd1000, 1'b1, 1'b1, 1'b0, "R5 hold on zero");
    cfg_a = 12'h001;
    step(16'd1000, 1'b1, 1'b1, 1'b0, "R5 clear on zero");

    // R10 priority
    cfg_a = 12'h092; cfg_b = 12'h000;
    write(2'd0, 16'd0, "R10 setup A=0");
    step(16'd0, 1'b1, 1'b1, 1'b0, "R10 zero beats compare A");
    cfg_a = 12'h090;
    step(16'd0, 1'b1, 1'b1, 1'b0, "R10 zero hold lets compare A act");
    write(2'd0, 16'd50, "R10 setup A=50");
    cfg_a = 12'h018;
    step(16'd50, 1'b1, 1'b0, 1'b1, "R10 period beats compare A");
    cfg_a = 12'h000; cfg_b = 12'h210;
    write(2'd1, 16'd50, "R10 setup B=50");
    step(16'd50, 1'b1, 1'b0, 1'b0, "R10 R11 compare A beats compare B");

    // R4 shadow modes: A zero, B period, C either, D immediate
    reload_mode = 8'hE4; cfg_a = 12'h000; cfg_b = 12'h000;
    write(2'd0, 16'd7, "R4 shadow write A");
    step(16'd7, 1'b1, 1'b0, 1'b0, "R4 A not loaded yet");
    step(16'd1000, 1'b1, 1'b0, 1'b1, "R4 period does not load A");
    step(16'd7, 1'b1, 1'b0, 1'b0, "R4 A still old");
    step(16'd1000, 1'b1, 1'b1, 1'b0, "R4 zero loads A");
    step(16'd7, 1'b1, 1'b0, 1'b0, "R4 A loaded");
    write(2'd1, 16'd9, "R4 shadow write B");
    step(16'd1000, 1'b1, 1'b1, 1'b0, "R4 zero does not load B");
    step(16'd9, 1'b1, 1'b0, 1'b0, "R4 B still old");
    step(16'd1000, 1'b1, 1'b0, 1'b1, "R4 period loads B");
    step(16'd9, 1'b1, 1'b0, 1'b0, "R4 B loaded");
    write(2'd2, 16'd11, "R4 shadow write C");
    step(16'd11, 1'b1, 1'b0, 1'b0, "R4 R12 C still old");
    step(16'd1000, 1'b1, 1'b0, 1'b1, "R4 period loads C");
    write(2'd2, 16'd12, "R4 shadow write C again");
    step(16'd1000, 1'b1, 1'b1, 1'b0, "R4 zero loads C");
    step(16'd12, 1'b1, 1'b0, 1'b0, "R4 R12 C loaded");
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd21;
    step(16'd1000, 1'b1, 1'b1, 1'b0, "R4 write and zero same edge");
    step(16'd21, 1'b1, 1'b0, 1'b0, "R4 written value loaded");
    write(2'd3, 16'd13, "R3 immediate write D");
    step(16'd13, 1'b1, 1'b0, 1'b0, "R3 R12 D loaded at once");

    step(16'd1000, 1'b1, 1'b0, 1'b0, "drain");
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule